// File: doc/BRIEF.md
# Start-Stop Receive Deserializer

This block turns a demodulated receive bit stream into characters. A sample strobe runs at a fixed multiple of the bit rate, eight by default. In start-stop mode the block finds the falling edge of a start bit and checks at mid-bit that the start is genuine. It then collects the data bits and an optional parity bit, lowest bit first, and examines the stop position. Each finished character goes into a holding register that the host reads at its own pace. Ready and overflow flags show whether the host is keeping up.

Parity is not compared against any setting. The block reports whether the data plus parity holds an even or an odd number of ones. A missing stop bit raises a framing error, but the character is still handed over. For rate adaptation, a missing stop bit can instead be accepted as the start of the next character. A line held low through a whole frame is a break. It is delivered with a framing error, and reception waits for the line to go high before it looks for the next falling edge. In synchronous mode the block ignores the length setting and simply packs every eight bits into a byte.

Top module: `rxs_deser`

## Requirements
- R1: The first received data bit lands in bit 0 of `rx_data`. The format code `cfg_fmt[2:1]` selects 5 + its value data bits (00=5, 01=6, 10=7, 11=8), and `cfg_fmt[0]`=1 adds one parity bit after the data. Bits above the selected length are don't-care.
- R2: A low level seen on a strobe while idle is taken as a start only if the line is still low half a bit later. Otherwise it is dropped and no character is produced.
- R3: `rx_par_even` is 1 when the valid data bits plus the parity bit (if present) hold an even number of ones, and 0 when they hold an odd number.
- R4: A low stop position with stop deletion disabled sets `rx_frame_err`, and the character is still delivered with `rx_ready` set.
- R5: With `cfg_stop_del`=1, a low stop position that is not a break is taken as the start bit of the next character. The character is delivered without a framing error, and the next character is assembled from that point.
- R6: A frame that is all zeros, including parity and stop, is delivered as zero data with `rx_frame_err` set. No further character is produced until the line has returned high and then falls again.
- R7: `rx_ready` goes high when a character completes and is cleared by a `status_rd` pulse. A `data_rd` pulse does not clear it.
- R8: A character that completes while the previous one has not been taken by `data_rd` sets `rx_overflow`, and the new character replaces the old one in `rx_data`. `data_rd` clears `rx_overflow`.
- R9: With `cfg_sync`=1, every eight bits form a byte, lowest bit first, whatever `cfg_fmt` says, and `rx_frame_err` stays 0. Bit timing counts from the release of reset.
- R10: After reset, `rx_data`, `rx_ready`, `rx_overflow`, `rx_par_even` and `rx_frame_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_en | input | 1 | Oversampling strobe, OSR per bit |
| rx_bit | input | 1 | Demodulated receive line, idle high |
| cfg_sync | input | 1 | 1 = synchronous eight-bit mode |
| cfg_fmt | input | 3 | Data length and parity presence code |
| cfg_stop_del | input | 1 | 1 = a missing stop bit is accepted as the next start |
| status_rd | input | 1 | Status read pulse, clears ready |
| data_rd | input | 1 | Data read pulse, clears overflow |
| rx_data | output | DW | Last received character |
| rx_ready | output | 1 | New character available |
| rx_overflow | output | 1 | A character was replaced before it was read |
| rx_par_even | output | 1 | Even-ones indication of the last character |
| rx_frame_err | output | 1 | Stop or break error on the last character |

## Verification
Clean start-stop characters are sent in all four lengths, with and without parity, and with parity bits chosen so that both even and odd results appear. This shows that the length code trims data correctly and that parity is counted over the right bits. Separate patterns cover a missing stop with deletion off and on, a held-low break followed by a long low tail, and a two-cycle low glitch. Together these separate the framing-error, rate-adaptation, resynchronisation and false-start paths. Back-to-back characters without reads, and two synchronous bytes with the length code set to five bits, show the overwrite on overflow, that ready and overflow are cleared by different reads, and that the length code is ignored in synchronous mode.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP,
    ST_HUNT
  } rx_state_e;

  // index of the final bit of a frame (data bits plus optional parity)
  function automatic logic [3:0] frame_last(input logic [2:0] fmt);
    return 4'd4 + {2'b00, fmt[2:1]} + {3'b000, fmt[0]};
  endfunction

endpackage

// File: rtl/rxs_frame.sv
module rxs_frame
  import rxs_pkg::*;
#(
  parameter int OSR = 8,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          rx,
  input  logic          cfg_sync,
  input  logic [2:0]    cfg_fmt,
  input  logic          cfg_del,
  output logic          char_vld,
  output logic [DW-1:0] char_data,
  output logic          char_par,
  output logic          char_ferr
);
  localparam int CW = (OSR > 1) ? $clog2(OSR) : 1;
  localparam int IW = $clog2(DW + 2);
  localparam logic [CW-1:0] MID_C = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] END_C = CW'(OSR - 1);
  localparam logic [IW-1:0] SYNC_LAST = IW'(DW - 1);

  rx_state_e     state;
  logic [CW-1:0] cnt;
  logic [IW-1:0] idx;
  logic [IW-1:0] last_idx;
  logic [DW:0]   sreg;

  always_ff @(posedge clk) begin
    char_vld <= 1'b0;
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      idx       <= '0;
      last_idx  <= '0;
      sreg      <= '0;
      char_data <= '0;
      char_par  <= 1'b0;
      char_ferr <= 1'b0;
    end else if (tick) begin
      if (cfg_sync) begin
        // free-running bit clock, eight bits per byte
        state <= ST_IDLE;
        cnt   <= (cnt == END_C) ? '0 : cnt + 1'b1;
        if (cnt == MID_C) begin
          sreg[idx] <= rx;
          if (idx == SYNC_LAST) begin
            idx       <= '0;
            char_vld  <= 1'b1;
            char_data <= {rx, sreg[DW-2:0]};
            char_par  <= ~^{rx, sreg[DW-2:0]};
            char_ferr <= 1'b0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
      end else begin
        unique case (state)
          ST_IDLE: begin
            if (!rx) begin
              state <= ST_START;
              cnt   <= '0;
            end
          end
          ST_START: begin
            if (cnt == MID_C) begin
              cnt <= '0;
              if (rx) begin
                state <= ST_IDLE;
              end else begin
                state    <= ST_DATA;
                idx      <= '0;
                sreg     <= '0;
                last_idx <= IW'(frame_last(cfg_fmt));
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_DATA: begin
            if (cnt == END_C) begin
              cnt       <= '0;
              sreg[idx] <= rx;
              if (idx == last_idx) state <= ST_STOP;
              else idx <= idx + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_STOP: begin
            if (cnt == END_C) begin
              cnt       <= '0;
              char_vld  <= 1'b1;
              char_data <= sreg[DW-1:0];
              char_par  <= ~^sreg;
              if (rx) begin
                char_ferr <= 1'b0;
                state     <= ST_IDLE;
              end else if (sreg == '0) begin
                char_ferr <= 1'b1;   // break
                state     <= ST_HUNT;
              end else if (cfg_del) begin
                char_ferr <= 1'b0;   // stop deleted: this low is the next start
                state     <= ST_DATA;
                idx       <= '0;
                sreg      <= '0;
                last_idx  <= IW'(frame_last(cfg_fmt));
              end else begin
                char_ferr <= 1'b1;
                state     <= ST_HUNT;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_HUNT: begin
            if (rx) state <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R2: a start that is high again at mid-bit yields no character
  p_glitch_drop_r2: assert property (@(posedge clk) disable iff (rst)
    (tick && !cfg_sync && state == ST_START && cnt == MID_C && rx)
      |=> (state == ST_IDLE && !char_vld));

  // R6: while waiting for the line to rise after an error, nothing is delivered
  p_hunt_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HUNT) |=> !char_vld);

  // R9: synchronous bytes never carry a framing error
  p_sync_noferr_r9: assert property (@(posedge clk) disable iff (rst)
    (char_vld && $past(cfg_sync)) |-> !char_ferr);

endmodule

// File: rtl/rxs_hold.sv
module rxs_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          char_vld,
  input  logic [DW-1:0] char_data,
  input  logic          char_par,
  input  logic          char_ferr,
  input  logic          status_rd,
  input  logic          data_rd,
  output logic [DW-1:0] rx_data,
  output logic          rx_ready,
  output logic          rx_overflow,
  output logic          rx_par_even,
  output logic          rx_frame_err
);
  logic unread;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data      <= '0;
      rx_ready     <= 1'b0;
      rx_overflow  <= 1'b0;
      rx_par_even  <= 1'b0;
      rx_frame_err <= 1'b0;
      unread       <= 1'b0;
    end else if (char_vld) begin
      rx_data      <= char_data;
      rx_par_even  <= char_par;
      rx_frame_err <= char_ferr;
      rx_ready     <= 1'b1;
      unread       <= 1'b1;
      rx_overflow  <= rx_overflow | unread;
    end else begin
      if (status_rd) rx_ready <= 1'b0;
      if (data_rd) begin
        rx_overflow <= 1'b0;
        unread      <= 1'b0;
      end
    end
  end

  // R7: a status read with no new character leaves ready low
  p_ready_clr_r7: assert property (@(posedge clk) disable iff (rst)
    (status_rd && !char_vld) |=> !rx_ready);

  // R8: a data read with no new character clears overflow
  p_ovf_clr_r8: assert property (@(posedge clk) disable iff (rst)
    (data_rd && !char_vld) |=> !rx_overflow);

  // R8: overflow only ever appears alongside a fresh character
  p_ovf_with_ready_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_overflow) |-> rx_ready);

  // R4: a character with a framing error is still presented as ready
  p_ferr_keeps_data_r4: assert property (@(posedge clk) disable iff (rst)
    (char_vld && char_ferr) |=> (rx_ready && rx_frame_err));

endmodule

// File: rtl/rxs_deser.sv
module rxs_deser #(
  parameter int OSR = 8,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sample_en,
  input  logic          rx_bit,
  input  logic          cfg_sync,
  input  logic [2:0]    cfg_fmt,
  input  logic          cfg_stop_del,
  input  logic          status_rd,
  input  logic          data_rd,
  output logic [DW-1:0] rx_data,
  output logic          rx_ready,
  output logic          rx_overflow,
  output logic          rx_par_even,
  output logic          rx_frame_err
);
  logic          char_vld;
  logic [DW-1:0] char_data;
  logic          char_par;
  logic          char_ferr;

  rxs_frame #(.OSR(OSR), .DW(DW)) u_frame (
    .clk       (clk),
    .rst       (rst),
    .tick      (sample_en),
    .rx        (rx_bit),
    .cfg_sync  (cfg_sync),
    .cfg_fmt   (cfg_fmt),
    .cfg_del   (cfg_stop_del),
    .char_vld  (char_vld),
    .char_data (char_data),
    .char_par  (char_par),
    .char_ferr (char_ferr)
  );

  rxs_hold #(.DW(DW)) u_hold (
    .clk          (clk),
    .rst          (rst),
    .char_vld     (char_vld),
    .char_data    (char_data),
    .char_par     (char_par),
    .char_ferr    (char_ferr),
    .status_rd    (status_rd),
    .data_rd      (data_rd),
    .rx_data      (rx_data),
    .rx_ready     (rx_ready),
    .rx_overflow  (rx_overflow),
    .rx_par_even  (rx_par_even),
    .rx_frame_err (rx_frame_err)
  );

endmodule

// File: tb/sim_rxs_deser.sv
module sim_rxs_deser;
  localparam int OSR = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx = 1'b1;
  logic       cfg_sync = 1'b0;
  logic [2:0] cfg_fmt = 3'b110;
  logic       cfg_del = 1'b0;
  logic       status_rd = 1'b0;
  logic       data_rd = 1'b0;
  logic [7:0] rx_data;
  logic       rx_ready, rx_overflow, rx_par_even, rx_frame_err;
  int         checks = 0;
  int         fails = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  rxs_deser #(.OSR(OSR), .DW(8)) u0 (
    .clk(clk), .rst(rst), .sample_en(1'b1), .rx_bit(rx),
    .cfg_sync(cfg_sync), .cfg_fmt(cfg_fmt), .cfg_stop_del(cfg_del),
    .status_rd(status_rd), .data_rd(data_rd),
    .rx_data(rx_data), .rx_ready(rx_ready), .rx_overflow(rx_overflow),
    .rx_par_even(rx_par_even), .rx_frame_err(rx_frame_err)
  );

  // {fmt, data, parity bit}
  localparam logic [11:0] VEC [0:6] = '{
    {3'b111, 8'hA5, 1'b1},
    {3'b110, 8'h3C, 1'b0},
    {3'b101, 8'hFF, 1'b0},
    {3'b100, 8'h55, 1'b0},
    {3'b011, 8'h2B, 1'b1},
    {3'b000, 8'h13, 1'b0},
    {3'b001, 8'h01, 1'b1}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int n);
    rx = v;
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] len_mask(input logic [2:0] f);
    return 8'hFF >> (2'd3 - f[2:1]);
  endfunction

  function automatic logic par_exp(input logic [2:0] f, input logic [7:0] d, input logic pb);
    return ~((^(d & len_mask(f))) ^ (f[0] & pb));
  endfunction

  task automatic send_char(input logic [2:0] f, input logic [7:0] d, input logic pb,
                           input logic stop_v, input int stop_n);
    hold(1'b0, OSR);
    for (int i = 0; i < 5 + int'(f[2:1]); i++) hold(d[i], OSR);
    if (f[0]) hold(pb, OSR);
    if (stop_n > 0) hold(stop_v, stop_n);
  endtask

  task automatic reads();
    status_rd = 1'b1;
    data_rd = 1'b1;
    @(negedge clk);
    status_rd = 1'b0;
    data_rd = 1'b0;
  endtask

  task automatic sync_byte(input logic [7:0] b, input bit rd_first);
    for (int i = 0; i < 8; i++) begin
      rx = b[i];
      if (i == 0 && rd_first) begin
        status_rd = 1'b1;
        data_rd = 1'b1;
      end
      @(negedge clk);
      status_rd = 1'b0;
      data_rd = 1'b0;
      repeat (OSR - 1) @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk({rx_data, rx_ready, rx_overflow, rx_par_even, rx_frame_err} == '0,
        "R10 reset outputs", {rx_data, rx_ready, rx_overflow, rx_par_even, rx_frame_err}, 0);
    hold(1'b1, 16);

    // R1 / R3 table of clean characters
    for (int v = 0; v < 7; v++) begin
      logic [2:0] f;
      logic [7:0] d;
      logic       pb;
      {f, d, pb} = VEC[v];
      cfg_fmt = f;
      send_char(f, d, pb, 1'b1, 16);
      chk(rx_ready == 1'b1, "R7 ready after char", rx_ready, 1);
      chk((rx_data & len_mask(f)) == (d & len_mask(f)), "R1 data", rx_data & len_mask(f), d & len_mask(f));
      chk(rx_par_even == par_exp(f, d, pb), "R3 parity status", rx_par_even, par_exp(f, d, pb));
      chk(rx_frame_err == 1'b0 && rx_overflow == 1'b0, "R4 clean char no errors",
          {rx_frame_err, rx_overflow}, 0);
      reads();
      chk(rx_ready == 1'b0, "R7 status read clears ready", rx_ready, 0);
    end

    // R8 overflow: two characters without reads
    cfg_fmt = 3'b110;
    send_char(3'b110, 8'h11, 1'b0, 1'b1, 16);
    send_char(3'b110, 8'hE7, 1'b0, 1'b1, 16);
    chk(rx_overflow == 1'b1, "R8 overflow set", rx_overflow, 1);
    chk(rx_data == 8'hE7, "R8 newer char overwrites", rx_data, 8'hE7);
    data_rd = 1'b1;
    @(negedge clk);
    data_rd = 1'b0;
    chk(rx_overflow == 1'b0, "R8 data read clears overflow", rx_overflow, 0);
    chk(rx_ready == 1'b1, "R7 data read leaves ready", rx_ready, 1);
    status_rd = 1'b1;
    @(negedge clk);
    status_rd = 1'b0;

    // R4 missing stop, deletion off
    send_char(3'b110, 8'h81, 1'b0, 1'b0, OSR);
    hold(1'b1, 16);
    chk(rx_ready == 1'b1 && rx_frame_err == 1'b1, "R4 framing error with data",
        {rx_ready, rx_frame_err}, 2'b11);
    chk(rx_data == 8'h81, "R4 data still delivered", rx_data, 8'h81);
    reads();
    send_char(3'b110, 8'h42, 1'b0, 1'b1, 16);
    chk(rx_frame_err == 1'b0 && rx_data == 8'h42, "R4 next clean char clears error",
        {rx_frame_err, rx_data}, {1'b0, 8'h42});
    reads();

    // R5 stop deletion
    cfg_del = 1'b1;
    send_char(3'b110, 8'h5A, 1'b0, 1'b1, 0);
    send_char(3'b110, 8'hC3, 1'b0, 1'b1, 16);
    chk(rx_data == 8'hC3, "R5 follow-on char", rx_data, 8'hC3);
    chk(rx_frame_err == 1'b0, "R5 no framing error", rx_frame_err, 0);
    chk(rx_overflow == 1'b1, "R5 two chars delivered", rx_overflow, 1);
    reads();
    cfg_del = 1'b0;

    // R6 break
    hold(1'b0, 80);
    chk(rx_ready && rx_frame_err && rx_data == 8'h00, "R6 break delivered with error",
        {rx_ready, rx_frame_err, rx_data}, {2'b11, 8'h00});
    rx = 1'b0;
    reads();
    hold(1'b0, 100);
    chk(rx_ready == 1'b0, "R6 no char while line stays low", rx_ready, 0);
    hold(1'b1, 16);
    send_char(3'b110, 8'h9C, 1'b0, 1'b1, 16);
    chk(rx_ready && rx_data == 8'h9C && !rx_frame_err, "R6 resync after rise",
        {rx_ready, rx_frame_err, rx_data}, {2'b10, 8'h9C});
    reads();

    // R2 glitch
    hold(1'b0, 2);
    hold(1'b1, 40);
    chk(rx_ready == 1'b0, "R2 glitch discarded", rx_ready, 0);

    // R9 synchronous mode, length code set to 5 bits
    cfg_sync = 1'b1;
    cfg_fmt = 3'b000;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    sync_byte(8'hB7, 1'b0);
    chk(rx_ready && rx_data == 8'hB7, "R9 first sync byte", {rx_ready, rx_data}, {1'b1, 8'hB7});
    sync_byte(8'h4E, 1'b1);
    chk(rx_ready && rx_data == 8'h4E && !rx_overflow && !rx_frame_err, "R9 second sync byte",
        {rx_ready, rx_overflow, rx_frame_err, rx_data}, {3'b100, 8'h4E});

    done = 1'b1;
    summary();
    $finish;
  end
endmodule